// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a small group of general-purpose input pins and raises one shared interrupt request whenever a pin that software has enabled changes level, rising or falling. Each pin is brought into the clock domain through a two-stage synchronizer. A change is found by comparing the synchronized level with the level one clock earlier. The changes on enabled pins are combined into a single sticky pending flag.

Software reaches three byte-wide registers over a simple register bus with address, write enable, write data and registered read data. The address map is: 0 = control (group enable at bit 0), 1 = status (pending flag at bit 0), 2 = pin select (one enable bit per pin at bits 3..0). Address 3 and all reserved bits read as zero. The interrupt request goes out only when the pending flag, the group enable and the CPU's global interrupt enable are all set. The flag clears when the CPU acknowledges the interrupt, or when software writes a one to bit 0 of the status register.

Top module: `pin_change_irq`

## Requirements
- R1: After reset the control, status and pin-select registers all read 0 and `irq_req` is 0.
- R2: Reserved bits read as zero: bits 7..1 of control (address 0), bits 7..1 of status (address 1), bits 7..4 of pin select (address 2), and all of address 3. Read data appears on `bus_rdata` one clock after the address is presented.
- R3: A rising level on a pin whose pin-select bit is 1 sets the pending flag (status bit 0).
- R4: A falling level on a pin whose pin-select bit is 1 sets the pending flag.
- R5: A level change on a pin whose pin-select bit is 0 never sets the pending flag.
- R6: `irq_req` is 1 in the cycle after pending flag, group enable (control bit 0) and `glob_ie` are all 1, and is 0 otherwise.
- R7: A one-cycle pulse on `irq_ack` clears the pending flag.
- R8: Writing a value with bit 0 = 1 to the status register clears the pending flag. Writing bit 0 = 0 leaves the flag unchanged.
- R9: When a qualifying pin change and a clear (by acknowledge or by write-one) fall in the same cycle, the flag ends up 1.
- R10: The pending flag is set by enabled pin changes while the group enable is 0, and `irq_req` rises once the group enable is then written to 1.
- R11: A pin change is seen in the pending flag on the third rising clock edge after the pin changes, and on `irq_req` on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | Asynchronous pins being watched |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| glob_ie | input | 1 | CPU global interrupt enable |
| irq_ack | input | 1 | CPU acknowledge; clears the pending flag |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
A vector table drives pin patterns against several pin-select masks. It covers single rising and falling edges, changes only on deselected pins, several pins changing at once, no change at all, and an empty mask, so edge polarity, mask gating and OR-combining can each fail on their own. Directed cases place a pin change in the very cycle of an acknowledge or a write-one clear, to separate set priority from clear priority. They also count the edges from a pin change to the flag and to the request, and step the two enables one at a time to show that the request is an AND of all three terms.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PINS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[p]};
    end
    assign q_sync[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/pci_edge_detect.sv
module pci_edge_detect #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] sel,
  output logic             hit
);
  logic [WIDTH-1:0] level_d;
  logic [WIDTH-1:0] toggled;

  always_ff @(posedge clk) begin
    if (rst) level_d <= '0;
    else     level_d <= level;
  end

  assign toggled = level ^ level_d;
  assign hit     = |(toggled & sel);
endmodule

// File: rtl/pci_regs.sv
module pci_regs
  import pin_change_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  input  logic              ack,
  input  logic              gie,
  output logic [DATA_W-1:0] rdata,
  output logic              flag_q,
  output logic              en_q,
  output logic [NUM_PINS-1:0] sel_q,
  output logic              irq_q
);
  localparam int PAD = DATA_W - NUM_PINS;

  logic wr_ctrl, wr_stat, wr_pins, clr;
  logic [DATA_W-1:0] rd_next;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_PINS];

  assign wr_ctrl = we && (addr == SEL_CTRL);
  assign wr_stat = we && (addr == SEL_STAT);
  assign wr_pins = we && (addr == SEL_PINS);
  assign clr     = ack || (wr_stat && wdata[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) en_q  <= wdata[0];
      if (wr_pins) sel_q <= wdata[NUM_PINS-1:0];
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      irq_q <= flag_q && en_q && gie;
    end
  end

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_CTRL: rd_next = {{(DATA_W-1){1'b0}}, en_q};
      SEL_STAT: rd_next = {{(DATA_W-1){1'b0}}, flag_q};
      SEL_PINS: rd_next = {{PAD{1'b0}}, sel_q};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                glob_ie,
  input  logic                irq_ack,
  output logic                irq_req
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_sel;
  logic                hit;
  logic                pend_flag;
  logic                grp_en;

  pci_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(pin_sync)
  );

  pci_edge_detect #(.WIDTH(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .level(pin_sync), .sel(pin_sel), .hit(hit)
  );

  pci_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .hit(hit), .ack(irq_ack), .gie(glob_ie), .rdata(bus_rdata),
    .flag_q(pend_flag), .en_q(grp_en), .sel_q(pin_sel), .irq_q(irq_req)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk
  import pin_change_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              glob_ie,
  input logic              irq_ack,
  input logic              irq_req,
  input logic              hit,
  input logic              pend_flag,
  input logic              grp_en
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:4] == '0);

  assert_hit_sets_R9: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend_flag);

  assert_set_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_flag) |-> $past(hit));

  assert_irq_on_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_flag && grp_en && glob_ie) |=> irq_req);

  assert_irq_off_R6: assert property (@(posedge clk) disable iff (rst)
    !(pend_flag && grp_en && glob_ie) |=> !irq_req);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !hit) |=> !pend_flag);

  assert_write_zero_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == SEL_STAT && !bus_wdata[0] && !irq_ack && pend_flag)
      |=> pend_flag);
endmodule

bind pin_change_irq pin_change_irq_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_ie(glob_ie),
  .irq_ack(irq_ack), .irq_req(irq_req), .hit(hit),
  .pend_flag(pend_flag), .grp_en(grp_en)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin_in = '0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       glob_ie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glob_ie(glob_ie), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // {mask, pins before, pins after, expected flag}; expected = |((before^after)&mask)
  localparam logic [12:0] VEC [8] = '{
    {4'hF, 4'b0000, 4'b0001, 1'b1},  // R3 rise
    {4'hF, 4'b0001, 4'b0000, 1'b1},  // R4 fall
    {4'h1, 4'b0000, 4'b1110, 1'b0},  // R5 deselected pins only
    {4'h8, 4'b0000, 4'b1000, 1'b1},  // R3 top pin
    {4'h0, 4'b0000, 4'b1111, 1'b0},  // R5 empty mask
    {4'h6, 4'b0110, 4'b0110, 1'b0},  // no change
    {4'h6, 4'b0110, 4'b0010, 1'b1},  // R4 fall on pin 2
    {4'h9, 4'b0110, 4'b0000, 1'b0}   // R5 falls on deselected pins
  };

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_we = 1'b0;
    tick();
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    tick(3);
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 irq", {7'd0, irq_req}, 8'h00);
    rd(2'd0, r); check("R1 ctrl", r, 8'h00);
    rd(2'd1, r); check("R1 stat", r, 8'h00);
    rd(2'd2, r); check("R1 pins", r, 8'h00);

    // R2 reserved bits
    wr(2'd0, 8'hFF); rd(2'd0, r); check("R2 ctrl", r, 8'h01);
    wr(2'd2, 8'hFF); rd(2'd2, r); check("R2 pins", r, 8'h0F);
    wr(2'd1, 8'hFF); rd(2'd1, r); check("R2 stat", r, 8'h00);
    rd(2'd3, r); check("R2 addr3", r, 8'h00);
    wr(2'd0, 8'h00);

    // table walk: R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, {4'h0, VEC[i][12:9]});
      pin_in = VEC[i][8:5];
      tick(4);
      wr(2'd1, 8'h01);
      tick();
      pin_in = VEC[i][4:1];
      tick(4);
      rd(2'd1, r);
      check($sformatf("R3/R4/R5 vec%0d", i), r, {7'd0, VEC[i][0]});
    end

    // R11 latency and R6 with all enables
    wr(2'd2, 8'h01); wr(2'd0, 8'h01); glob_ie = 1'b1;
    wr(2'd1, 8'h01); tick(2);
    bus_addr = 2'd1;
    pin_in[0] = ~pin_in[0];
    tick(3);
    check("R11 irq at edge3", {7'd0, irq_req}, 8'h00);
    check("R11 flag at edge3", bus_rdata, 8'h00);
    tick();
    check("R11 irq at edge4", {7'd0, irq_req}, 8'h01);
    check("R11 flag at edge4", bus_rdata, 8'h01);

    // R6 global enable gates request
    glob_ie = 1'b0; tick();
    check("R6 gie low", {7'd0, irq_req}, 8'h00);
    glob_ie = 1'b1; tick();
    check("R6 gie high", {7'd0, irq_req}, 8'h01);

    // R8 write zero keeps, write one clears
    wr(2'd1, 8'hFE); rd(2'd1, r); check("R8 write zero", r, 8'h01);
    wr(2'd1, 8'h01); rd(2'd1, r); check("R8 write one", r, 8'h00);
    tick();
    check("R6 flag low", {7'd0, irq_req}, 8'h00);

    // R10 flag sets while group disabled, request after enable
    wr(2'd0, 8'h00);
    pin_in[0] = ~pin_in[0];
    tick(4);
    check("R10 irq while disabled", {7'd0, irq_req}, 8'h00);
    rd(2'd1, r); check("R10 flag while disabled", r, 8'h01);
    wr(2'd0, 8'h01); tick();
    check("R10 irq after enable", {7'd0, irq_req}, 8'h01);

    // R7 acknowledge clears
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    rd(2'd1, r); check("R7 ack clears", r, 8'h00);
    check("R7 irq drops", {7'd0, irq_req}, 8'h00);

    // R9 set wins over simultaneous acknowledge
    pin_in[0] = ~pin_in[0];
    tick(2);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    rd(2'd1, r); check("R9 set beats ack", r, 8'h01);
    wr(2'd1, 8'h01); tick(2);

    // R9 set wins over simultaneous write-one
    pin_in[0] = ~pin_in[0];
    tick(2);
    wr(2'd1, 8'h01);
    rd(2'd1, r); check("R9 set beats write-one", r, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule